// File: doc/BRIEF.md
# E1 CRC-4 Interworking Alarm Supervisor

This block decides what an E1 transmitter places in its remote alarm bit and its E-bits while the receiver hunts for CRC-4 multiframe alignment. A framer feeds it a basic-frame strobe, a reframe event, a level saying a valid CRC multiframe is being received, and a CRC sync status bit that is 1 while CRC sync is missing. A 1 ms tick from elsewhere in the chip times the hunt.

When a reframe attempt comes without valid CRC multiframe alignment, the block enters a flicker phase. In that phase the alarm bit goes high for one basic frame after each reframe attempt. If the phase runs for `FLICKER_MS` milliseconds without alignment, one of two fallbacks follows. With automatic interworking enabled, the link drops to non-CRC operation: the search and the check stop, the alarm goes low, and a status flag is raised. With automatic interworking disabled, the alarm stays high and the search goes on until CRC sync is found. A force control holds the alarm at a chosen level in every state. All control inputs are sampled at the frame strobe, so the alarm bit never changes in the middle of a frame.

Top module: `crc_iw_alarm`

## Requirements
- R1: When `rai_force`=1 at a frame strobe, `tx_rai` takes the value of `rai_level` from the clock after that strobe. This holds for any `iw_disable` value and in every state.
- R2: With `rai_force`=0, a `reframe` pulse while `crc_mf_ok`=0, in normal or flicker state, sets `tx_rai` to 1 at the next frame strobe. `tx_rai` returns to 0 at the strobe after that, unless another such reframe occurred in between.
- R3: The fallback is entered in the clock after the `FLICKER_MS`-th `ms_tick` counted from entry to flicker. After `FLICKER_MS`-1 ticks, no fallback has occurred.
- R4: Fallback with `iw_disable`=0 gives `non_crc_mode`=1, `crc_search_en`=0 and `crc_check_en`=0, with `tx_rai` driven 0 at each strobe unless forced. This state holds until reset, even across later reframes.
- R5: Fallback with `iw_disable`=1 drives `tx_rai` to 1 at every frame strobe unless forced, with `crc_search_en` and `crc_check_en` held at 1 and `non_crc_mode` at 0.
- R6: In the high fallback, `crc_sync_lost`=0 returns the block to normal. `tx_rai` is 0 from the next frame strobe and `tx_ebit` follows `ebit_rpt` again.
- R7: `crc_mf_ok`=1 during flicker clears the timer and any pending pulse and returns to normal. `tx_rai` is 0 at the next strobe, and later ticks cause no fallback.
- R8: In either fallback, `tx_ebit` equals the `ebit_ctl` value sampled at the last frame strobe. Outside fallback, `tx_ebit` equals `ebit_rpt`.
- R9: `tx_rai` and the sampled control bits change only at a frame strobe. A control change between strobes leaves `tx_rai` unchanged until the next strobe.
- R10: After reset: `tx_rai`=0, `crc_search_en`=1, `crc_check_en`=1, `non_crc_mode`=0, and `tx_ebit` follows `ebit_rpt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_stb | input | 1 | One-cycle pulse at each basic frame start |
| reframe | input | 1 | One-cycle pulse at each reframe attempt |
| crc_mf_ok | input | 1 | Valid CRC multiframe alignment being received |
| crc_sync_lost | input | 1 | 1 while CRC sync is missing, 0 once found |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| iw_disable | input | 1 | 1 turns off automatic interworking fallback |
| rai_force | input | 1 | 1 holds the alarm at `rai_level` |
| rai_level | input | 1 | Forced alarm level |
| ebit_ctl | input | 1 | E-bit value sent during fallback |
| ebit_rpt | input | 1 | E-bit value sent outside fallback |
| tx_rai | output | 1 | Transmit remote alarm bit |
| tx_ebit | output | 1 | Transmit E-bit value |
| crc_search_en | output | 1 | CRC multiframe search enable |
| crc_check_en | output | 1 | CRC-4 check enable |
| non_crc_mode | output | 1 | Link has fallen back to non-CRC operation |

## Verification
A wrong internal state shows at the ports within one frame. A lost or stuck pending pulse shows as `tx_rai` at the wrong level at the first strobe after a reframe. A timer that is off by one shows as the status outputs flipping one tick early, or not at all, when the bench counts ticks exactly. A wrong fallback choice, or a failure to leave the high fallback, shows as `tx_rai`, `tx_ebit` or the enables disagreeing with the requirement at the very next strobe.

// File: rtl/crc_iw_alarm.sv
module crc_iw_alarm #(
  parameter int FLICKER_MS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic reframe,
  input  logic crc_mf_ok,
  input  logic crc_sync_lost,
  input  logic ms_tick,
  input  logic iw_disable,
  input  logic rai_force,
  input  logic rai_level,
  input  logic ebit_ctl,
  input  logic ebit_rpt,
  output logic tx_rai,
  output logic tx_ebit,
  output logic crc_search_en,
  output logic crc_check_en,
  output logic non_crc_mode
);

  localparam int CW = (FLICKER_MS > 1) ? $clog2(FLICKER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLICKER_MS - 1);

  typedef enum logic [1:0] {S_NORM, S_FLICK, S_FB_HI, S_FB_LO} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          autc_q;
  logic          te_q;

  wire hunting   = (state == S_NORM) || (state == S_FLICK);
  wire miss      = reframe && !crc_mf_ok && hunting;
  wire expire    = (state == S_FLICK) && ms_tick && (cnt == LAST) && !crc_mf_ok;
  wire fallback  = (state == S_FB_HI) || (state == S_FB_LO);

  assign tx_ebit       = fallback ? te_q : ebit_rpt;
  assign crc_search_en = (state != S_FB_LO);
  assign crc_check_en  = (state != S_FB_LO);
  assign non_crc_mode  = (state == S_FB_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autc_q <= 1'b0;
      te_q   <= 1'b0;
    end else if (frame_stb) begin
      autc_q <= iw_disable;
      te_q   <= ebit_ctl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_NORM;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_NORM: begin
          cnt <= '0;
          if (miss) state <= S_FLICK;
        end
        S_FLICK: begin
          if (crc_mf_ok) begin
            state <= S_NORM;
            cnt   <= '0;
          end else if (expire) begin
            state <= autc_q ? S_FB_HI : S_FB_LO;
            cnt   <= '0;
          end else if (ms_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FB_HI: if (!crc_sync_lost) state <= S_NORM;
        S_FB_LO: state <= S_FB_LO;
        default: state <= S_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend <= 1'b0;
    else if (miss)                       pend <= 1'b1;
    else if (frame_stb || crc_mf_ok || !hunting) pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_rai <= 1'b0;
    else if (frame_stb) begin
      if (rai_force)                tx_rai <= rai_level;
      else if (state == S_FB_HI)    tx_rai <= 1'b1;
      else if (state == S_FB_LO)    tx_rai <= 1'b0;
      else                          tx_rai <= pend && !crc_mf_ok;
    end
  end

  assert_rai_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && rai_force |=> tx_rai == $past(rai_level));

  assert_rai_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(tx_rai));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_noncrc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    non_crc_mode |=> non_crc_mode);

  assert_fblo_rai_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && !rai_force && non_crc_mode |=> !tx_rai);

  assert_fbhi_rai_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && !rai_force && state == S_FB_HI |=> tx_rai);

  assert_fb_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FB_HI |-> crc_search_en && !non_crc_mode);

endmodule

// File: tb/crc_iw_alarm_bench.sv
module crc_iw_alarm_bench;
  localparam int FMS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 0, reframe = 0, crc_mf_ok = 0, crc_sync_lost = 1, ms_tick = 0;
  logic iw_disable = 0, rai_force = 0, rai_level = 0, ebit_ctl = 0, ebit_rpt = 0;
  logic tx_rai, tx_ebit, crc_search_en, crc_check_en, non_crc_mode;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  crc_iw_alarm #(.FLICKER_MS(FMS)) u_crc_iw_alarm (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .reframe(reframe),
    .crc_mf_ok(crc_mf_ok), .crc_sync_lost(crc_sync_lost), .ms_tick(ms_tick),
    .iw_disable(iw_disable), .rai_force(rai_force), .rai_level(rai_level),
    .ebit_ctl(ebit_ctl), .ebit_rpt(ebit_rpt), .tx_rai(tx_rai), .tx_ebit(tx_ebit),
    .crc_search_en(crc_search_en), .crc_check_en(crc_check_en),
    .non_crc_mode(non_crc_mode));

  // {iw_disable, rai_force, rai_level, ebit_ctl, ebit_rpt, exp_rai, exp_ebit}
  localparam logic [6:0] VEC [8] = '{
    7'b0_1_1_0_0_1_0, 7'b1_1_1_1_1_1_1, 7'b0_1_0_1_0_0_0, 7'b1_1_0_0_1_0_1,
    7'b0_0_1_0_1_0_1, 7'b1_0_1_1_0_0_0, 7'b0_1_1_1_1_1_1, 7'b1_0_0_0_0_0_0};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_stb();
    @(negedge clk) frame_stb = 1;
    @(negedge clk) frame_stb = 0;
  endtask

  task automatic pulse_ref();
    @(negedge clk) reframe = 1;
    @(negedge clk) reframe = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1;
      @(negedge clk) ms_tick = 0;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rai", tx_rai, 0);
    check("R10 search", crc_search_en, 1);
    check("R10 chk", crc_check_en, 1);
    check("R10 noncrc", non_crc_mode, 0);
    ebit_rpt = 1; #1;
    check("R10 ebit", tx_ebit, 1);
    @(negedge clk) rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {iw_disable, rai_force, rai_level, ebit_ctl, ebit_rpt} = VEC[v][6:2];
      pulse_stb();
      check("R1 table rai", tx_rai, VEC[v][1]);
      check("R8 table ebit", tx_ebit, VEC[v][0]);
    end

    // R9: control change without strobe
    @(negedge clk) rai_force = 1; rai_level = 1;
    repeat (4) @(negedge clk);
    check("R9 hold", tx_rai, 0);
    pulse_stb();
    check("R9 at strobe", tx_rai, 1);
    @(negedge clk) rai_force = 0; rai_level = 0; iw_disable = 1; ebit_ctl = 1; ebit_rpt = 0;
    pulse_stb();
    check("R9 release", tx_rai, 0);

    // R2 flicker pulse
    pulse_ref();
    check("R2 no change before strobe", tx_rai, 0);
    pulse_stb();
    check("R2 pulse high", tx_rai, 1);
    pulse_stb();
    check("R2 one frame only", tx_rai, 0);

    // R3 timer boundary, then R5 high fallback
    ticks(FMS - 1);
    check("R3 no early fallback", crc_search_en, 1);
    check("R8 ebit outside fallback", tx_ebit, 0);
    pulse_stb();
    check("R3 no early rai", tx_rai, 0);
    ticks(1);
    check("R8 ebit in fallback hi", tx_ebit, 1);
    pulse_stb();
    check("R5 rai high", tx_rai, 1);
    pulse_stb();
    check("R5 rai stays high", tx_rai, 1);
    check("R5 search on", crc_search_en, 1);
    check("R5 check on", crc_check_en, 1);
    check("R5 not noncrc", non_crc_mode, 0);

    // R6 exit on sync
    @(negedge clk) crc_sync_lost = 0;
    @(negedge clk) crc_sync_lost = 1;
    check("R6 ebit back", tx_ebit, 0);
    pulse_stb();
    check("R6 rai low", tx_rai, 0);

    // R7 alignment during flicker
    pulse_ref();
    ticks(3);
    @(negedge clk) crc_mf_ok = 1;
    @(negedge clk) crc_mf_ok = 0;
    pulse_stb();
    check("R7 rai low", tx_rai, 0);
    ticks(FMS + 1);
    pulse_stb();
    check("R7 no fallback rai", tx_rai, 0);
    check("R7 no fallback ebit", tx_ebit, 0);

    // R4 non-CRC fallback
    @(negedge clk) iw_disable = 0; ebit_ctl = 1;
    pulse_stb();
    pulse_ref();
    ticks(FMS);
    check("R4 noncrc", non_crc_mode, 1);
    check("R4 search off", crc_search_en, 0);
    check("R4 check off", crc_check_en, 0);
    check("R8 ebit fallback lo", tx_ebit, 1);
    pulse_stb();
    check("R4 rai low", tx_rai, 0);
    pulse_ref();
    pulse_stb();
    check("R4 sticky rai", tx_rai, 0);
    check("R4 sticky flag", non_crc_mode, 1);
    @(negedge clk) rai_force = 1; rai_level = 1;
    pulse_stb();
    check("R1 force in fallback", tx_rai, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule